// File: doc/BRIEF.md
# Parity-Framed Serial Master with Idle Sleep

This block is a single-clock serial master in SPI mode 0 that serves two peripherals. Each peripheral has its own active-low select. The host puts a byte on `dataIn`, picks a target with `slaveIdx`, and pulses either `start` or the event input `irq`. The master then clocks out a 9-bit frame: the byte MSB first, followed by an even parity bit, which is the XOR of the eight data bits. On the same SCK edges it collects nine bits from `miso`. It keeps the first eight of those bits as `dataOut` and pulses `done`.

A transfer sequencer steps through idle, select, shift and release phases. A separate power sequencer watches for inactivity. Once the block has been idle for `IDLE_CYCLES` clocks it drops `powerOn`. The next `start` or `irq` raises `powerOn` again, and the waiting transfer begins one clock after that.

Top module: `spi_parity_master`

## Requirements
- R1: After reset both selects are high (`ssN` = 2'b11), `sck`, `mosi`, `busy` and `done` are 0, `dataOut` is 0 and `powerOn` is 1.
- R2: While idle and powered, a one-cycle pulse on `start`, on `irq` or on both launches exactly one transfer. `dataIn` and `slaveIdx` are captured on the accepting clock edge.
- R3: `slaveIdx` = 0 drives `ssN[0]` low and `slaveIdx` = 1 drives `ssN[1]` low. The select goes low from the cycle after acceptance until the frame ends, and the other select stays high. Both selects are high when no frame is in progress.
- R4: A frame has exactly 9 rising SCK edges and SCK idles low. MOSI carries `dataIn[7]` down to `dataIn[0]`, then the XOR of those bits. MOSI changes only while SCK is low, so each bit is stable at its rising edge.
- R5: One SCK period is `DIV` clocks (default 4). SCK is high for `DIV - DIV/2` of those clocks.
- R6: MISO is sampled on each rising SCK edge. `dataOut` takes the first eight samples, MSB first, in the cycle that `done` is high. The ninth sample is dropped, and `dataOut` holds its value at all other times.
- R7: `done` is a one-cycle pulse 9*DIV+2 clocks after the accepting edge, with both selects already high. `busy` is high from the accepting edge through the `done` cycle.
- R8: A `start` or `irq` that arrives while `busy` is high is ignored. The frame in progress is unchanged and no second transfer follows.
- R9: With no activity, `powerOn` falls `IDLE_CYCLES`+1 clock edges after `busy` falls.
- R10: A request while `powerOn` is low is accepted. `powerOn` and `busy` rise on the next edge with both selects still high, and the select goes low one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | DATA_W | Byte to send |
| slaveIdx | input | 1 | Target peripheral (0 or 1) |
| start | input | 1 | Host launch pulse |
| irq | input | 1 | Event launch pulse |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the peripheral |
| ssN | output | 2 | Active-low peripheral selects |
| dataOut | output | DATA_W | Last received byte |
| busy | output | 1 | Transfer accepted or in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| powerOn | output | 1 | Low after the idle timeout |

## Verification
The assertions run on every clock and check the select rules: at most one select low, no select while idle, no select change mid-frame and no SCK without a select. They also check that `done` lasts one cycle, that `dataOut` changes only at `done`, that the block never works while powered down and that a request wakes it on the next edge. Only the bench scenarios can show the actual content of a frame. That covers the MOSI bit order and parity for every byte value, the MISO bytes it assembles, the SCK pulse count and duty, the exact `done` latency, the idle timeout count and the one-cycle extra latency after a wake-up.

// File: rtl/spiMasterPkg.sv
`timescale 1ns/1ps
package spiMasterPkg;

  typedef enum logic [1:0] {
    X_IDLE,
    X_SELECT,
    X_SHIFT,
    X_RELEASE
  } xferState_t;

  typedef enum logic [1:0] {
    P_ON,
    P_WAIT,
    P_OFF
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture byte and parity into the transmit shifter
    logic selActive;  // a peripheral is selected, mosi drives data
    logic run;        // shift phase, serial clock runs
    logic capture;    // copy received byte to the output register
  } ctrlStrobes_t;

  // status from datapath to control
  typedef struct packed {
    logic frameEnd;   // last clock of the last bit
  } dpStatus_t;

endpackage

// File: rtl/spiCtrl.sv
`timescale 1ns/1ps
module spiCtrl
  import spiMasterPkg::*;
#(
  parameter int IDLE_CYCLES = 16,
  parameter int NUM_SEL     = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               irq,
  input  logic               slaveIdx,
  input  dpStatus_t          dpStat,
  output ctrlStrobes_t       strobes,
  output logic [NUM_SEL-1:0] ssN,
  output logic               busy,
  output logic               done,
  output logic               powerOn
);

  localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);

  xferState_t xState, xNext;
  pwrState_t  pState;
  logic       pending;
  logic       selIdx;
  logic [IDLE_W-1:0] idleCnt;

  logic req, xIdle, accept, go;

  assign req    = start | irq;
  assign xIdle  = (xState == X_IDLE) && !pending;
  assign accept = xIdle && req;
  assign go     = (accept && (pState != P_OFF)) || pending;

  always_comb begin
    xNext = xState;
    unique case (xState)
      X_IDLE:    if (go) xNext = X_SELECT;
      X_SELECT:  xNext = X_SHIFT;
      X_SHIFT:   if (dpStat.frameEnd) xNext = X_RELEASE;
      X_RELEASE: xNext = X_IDLE;
      default:   xNext = X_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xState  <= X_IDLE;
      pending <= 1'b0;
      selIdx  <= 1'b0;
    end else begin
      xState <= xNext;
      if (accept && (pState == P_OFF)) pending <= 1'b1;
      else if (pending)                pending <= 1'b0;
      if (accept) selIdx <= slaveIdx;
    end
  end

  // power sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pState  <= P_ON;
      idleCnt <= '0;
    end else begin
      unique case (pState)
        P_ON: begin
          if (xIdle && !req) begin
            pState  <= P_WAIT;
            idleCnt <= '0;
          end
        end
        P_WAIT: begin
          if (req || !xIdle)                          pState <= P_ON;
          else if (idleCnt == IDLE_W'(IDLE_CYCLES-1)) pState <= P_OFF;
          else                                        idleCnt <= idleCnt + 1'b1;
        end
        P_OFF:   if (req) pState <= P_ON;
        default: pState <= P_ON;
      endcase
    end
  end

  logic framing;
  assign framing = (xState == X_SELECT) || (xState == X_SHIFT);

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    assign ssN[i] = !(framing && (selIdx == 1'(i)));
  end

  assign strobes.load      = accept;
  assign strobes.selActive = framing;
  assign strobes.run       = (xState == X_SHIFT);
  assign strobes.capture   = (xState == X_SHIFT) && dpStat.frameEnd;

  assign busy    = (xState != X_IDLE) || pending;
  assign done    = (xState == X_RELEASE);
  assign powerOn = (pState != P_OFF);

endmodule

// File: rtl/spiDatapath.sv
`timescale 1ns/1ps
module spiDatapath
  import spiMasterPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              miso,
  output dpStatus_t         dpStat,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] dataOut
);

  localparam int FRAME_BITS = DATA_W + 1;
  localparam int HALF       = DIV / 2;
  localparam int DIV_W      = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  logic [DIV_W-1:0]      divCnt;
  logic [BIT_W-1:0]      bitCnt;
  logic [FRAME_BITS-1:0] txShift;
  logic [FRAME_BITS-1:0] rxShift;
  logic bitEnd, sampleNow;

  assign bitEnd    = strobes.run && (divCnt == DIV_W'(DIV-1));
  assign sampleNow = strobes.run && (divCnt == DIV_W'(HALF-1));
  assign dpStat.frameEnd = bitEnd && (bitCnt == BIT_W'(FRAME_BITS-1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      bitCnt <= '0;
    end else if (!strobes.run) begin
      divCnt <= '0;
      bitCnt <= '0;
    end else if (bitEnd) begin
      divCnt <= '0;
      bitCnt <= bitCnt + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobes.load) begin
      txShift <= {dataIn, ^dataIn};
    end else if (bitEnd) begin
      txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (sampleNow) begin
      rxShift <= {rxShift[FRAME_BITS-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
    end else if (strobes.capture) begin
      dataOut <= rxShift[FRAME_BITS-1:1];
    end
  end

  assign sck  = strobes.run && (divCnt >= DIV_W'(HALF));
  assign mosi = strobes.selActive && txShift[FRAME_BITS-1];

endmodule

// File: rtl/spi_parity_master.sv
`timescale 1ns/1ps
module spi_parity_master
  import spiMasterPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV         = 4,
  parameter int IDLE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              slaveIdx,
  input  logic              start,
  input  logic              irq,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [1:0]        ssN,
  output logic [DATA_W-1:0] dataOut,
  output logic              busy,
  output logic              done,
  output logic              powerOn
);

  ctrlStrobes_t strobes;
  dpStatus_t    dpStat;

  spiCtrl #(
    .IDLE_CYCLES(IDLE_CYCLES),
    .NUM_SEL    (2)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .irq     (irq),
    .slaveIdx(slaveIdx),
    .dpStat  (dpStat),
    .strobes (strobes),
    .ssN     (ssN),
    .busy    (busy),
    .done    (done),
    .powerOn (powerOn)
  );

  spiDatapath #(
    .DATA_W(DATA_W),
    .DIV   (DIV)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .dataIn (dataIn),
    .miso   (miso),
    .dpStat (dpStat),
    .sck    (sck),
    .mosi   (mosi),
    .dataOut(dataOut)
  );

endmodule

// File: rtl/spiMasterChecker.sv
`timescale 1ns/1ps
module spiMasterChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              irq,
  input logic              sck,
  input logic [1:0]        ssN,
  input logic [DATA_W-1:0] dataOut,
  input logic              busy,
  input logic              done,
  input logic              powerOn
);

  p_one_select_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~ssN) <= 1);

  p_idle_deselect_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ssN == 2'b11));

  p_select_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((ssN != 2'b11) && ($past(ssN) != 2'b11)) |-> $stable(ssN));

  p_clock_needs_select_r4: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> (ssN != 2'b11));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_released_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((ssN == 2'b11) && busy));

  p_result_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> done);

  p_busy_powered_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> powerOn);

  p_wake_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!powerOn && (start || irq)) |=> (powerOn && busy));

endmodule

bind spi_parity_master spiMasterChecker #(.DATA_W(DATA_W)) u_checker (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .irq    (irq),
  .sck    (sck),
  .ssN    (ssN),
  .dataOut(dataOut),
  .busy   (busy),
  .done   (done),
  .powerOn(powerOn)
);

// File: tb/test_spi_parity_master.sv
`timescale 1ns/1ps
module test_spi_parity_master;

  localparam int DW  = 8;
  localparam int DIV = 4;
  localparam int IC  = 16;
  localparam int FRAME_CLKS = 9 * DIV;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic slaveIdx = 1'b0;
  logic start = 1'b0;
  logic irq = 1'b0;
  logic miso;
  logic sck, mosi, busy, done, powerOn;
  logic [1:0] ssN;
  logic [DW-1:0] dataOut;

  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;

  spi_parity_master #(.DATA_W(DW), .DIV(DIV), .IDLE_CYCLES(IC)) i_spi_parity_master (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .slaveIdx(slaveIdx),
    .start(start), .irq(irq), .miso(miso), .sck(sck), .mosi(mosi),
    .ssN(ssN), .dataOut(dataOut), .busy(busy), .done(done), .powerOn(powerOn)
  );

  // peripheral model: presents bit 8 first, advances on falling SCK
  logic [8:0] slvShift = '0;
  logic [8:0] mosiCap = '0;
  int riseCnt = 0;
  int ssBad = 0;
  logic [1:0] expSs = 2'b11;

  assign miso = slvShift[8];

  always @(negedge sck) slvShift <= {slvShift[7:0], 1'b0};

  always @(posedge sck) begin
    mosiCap <= {mosiCap[7:0], mosi};
    riseCnt <= riseCnt + 1;
    if (ssN !== expSs) ssBad <= ssBad + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; mode bit0 = start, bit1 = irq; lat = 1 when waking from off
  task automatic runXfer(input logic [7:0] d, input logic idx, input int mode,
                         input logic [8:0] vec, input int lat, input bit inject);
    int doneK = -1;
    int doneCnt = 0;
    int busyBad = 0;
    int highCnt = 0;
    logic [8:0] expFrame;
    expFrame = {d, ^d};
    expSs    = idx ? 2'b01 : 2'b10;
    slvShift = vec;
    mosiCap  = '0;
    riseCnt  = 0;
    ssBad    = 0;
    dataIn   = d;
    slaveIdx = idx;
    start    = mode[0];
    irq      = mode[1];
    for (int k = 1; k <= 3 + FRAME_CLKS + lat; k++) begin
      @(negedge clk);
      if (k == 1) begin
        start = 1'b0; irq = 1'b0; dataIn = ~d; slaveIdx = ~idx;
        if (lat == 1)
          check(powerOn && busy && (ssN == 2'b11), "R10", {powerOn, busy, ssN}, 4'b1111);
      end
      if (inject && k == 6) begin start = 1'b1; irq = 1'b1; dataIn = 8'h5A; end
      if (inject && k == 7) begin start = 1'b0; irq = 1'b0; end
      if (k == 1 + lat) check(ssN == expSs, "R3", ssN, expSs);
      if (sck) highCnt++;
      if (done) begin doneK = k; doneCnt++; end
      if (busy !== (k <= 2 + FRAME_CLKS + lat)) busyBad++;
    end
    check(doneCnt == 1 && doneK == 2 + FRAME_CLKS + lat, "R7", doneK, 2 + FRAME_CLKS + lat);
    check(busyBad == 0, inject ? "R8" : "R7", busyBad, 0);
    check(riseCnt == 9, "R4", riseCnt, 9);
    check(mosiCap == expFrame, inject ? "R8" : "R4", mosiCap, expFrame);
    check(ssBad == 0 && ssN == 2'b11, "R3", ssBad, 0);
    check(highCnt == 9 * (DIV - DIV / 2), "R5", highCnt, 9 * (DIV - DIV / 2));
    check(dataOut == vec[8:1], "R6", dataOut, vec[8:1]);
    expSs = 2'b11;
  endtask

  task automatic sleepCheck();
    // caller is at the negedge right after busy fell
    for (int j = 1; j <= IC + 1; j++) begin
      @(negedge clk);
      if (j == IC) check(powerOn == 1'b1, "R9", powerOn, 1);
      if (j == IC + 1) check(powerOn == 1'b0, "R9", powerOn, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ssN == 2'b11, "R1", ssN, 3);
    check(!sck && !mosi, "R1", {sck, mosi}, 0);
    check(!busy && !done, "R1", {busy, done}, 0);
    check(dataOut == '0, "R1", dataOut, 0);
    check(powerOn == 1'b1, "R1", powerOn, 1);

    // sweep over every byte, both targets, all three launch kinds (R2)
    for (int d = 0; d < 256; d++) begin
      logic [7:0] db;
      logic [7:0] rv;
      db = 8'(d);
      rv = 8'(d * 37 + 11);
      runXfer(db, db[0] ^ db[3], 1 + (d % 3), {rv, db[5]}, 0, (d % 17) == 0);
    end

    // idle timeout, then wake with start (R9, R10)
    sleepCheck();
    runXfer(8'hC3, 1'b1, 1, 9'h1A5, 1, 1'b0);
    sleepCheck();
    runXfer(8'h01, 1'b0, 2, 9'h0FF, 1, 1'b0);
    sleepCheck();
    runXfer(8'hFE, 1'b1, 3, 9'h100, 1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule